// File: doc/BRIEF.md
# AXI4-to-AXI3 Write Burst Converter

This block sits between an AXI4 write master and an AXI3 write slave. It accepts AXI4 address bursts of up to 256 beats and breaks each one into downstream bursts of at most 16 beats. Every later piece starts at the next aligned address. Write data passes straight through, with no buffering. The converter adds a write ID to every beat and rebuilds the last-beat marker at each split boundary. The downstream write responses that belong to one upstream burst are folded into a single upstream response that carries the most severe status.

Two small queues carry per-burst information from the address issuer to the data framer and to the response merger. The address side can therefore run several bursts ahead of the data, and data beats never wait for responses. Response merging only works if downstream responses come back in issue order, so the converter holds back a new upstream address whose ID differs from the ID still in flight. It waits until every earlier transaction has been answered.

Top module: `axw_conv`

## Requirements
- R1: An upstream burst with length field L (L+1 beats) produces ceil((L+1)/16) downstream bursts, issued in order. Every piece except the last has length field 15 (16 beats). The last piece carries the remaining beats.
- R2: The first piece uses the upstream address. Each later piece uses the previous piece's address, rounded down to a multiple of 2^AWSIZE bytes, plus 16·2^AWSIZE. Every piece copies the upstream AWID and AWSIZE, and a downstream address held without ready keeps its value.
- R3: An upstream address is accepted only while no split is in progress, so `up_awready` is low in the cycle after any upstream address handshake.
- R4: Each downstream beat carries the upstream data and strobes unchanged. Its `dn_wid` equals the AWID of the burst the beat belongs to. `dn_wlast` is high on the 16th beat of each full piece and on the final beat of the last piece. Beat framing comes only from the address length; there is no upstream last input.
- R5: The data path is combinational. Once a downstream burst has been issued and not yet fully written, `up_wready` follows `dn_wready` in the same cycle, and the beat is forwarded regardless of pending responses.
- R6: Exactly one upstream response is returned per upstream address, in order, with `up_bid` equal to its AWID. `up_bvalid` stays low while a response for a non-final piece is offered downstream.
- R7: The upstream BRESP is the numerically largest code among the transaction's downstream responses (OKAY=0 < EXOKAY=1 < SLVERR=2 < DECERR=3). The accumulator starts from OKAY for every transaction.
- R8: While any upstream transaction is unanswered, an upstream address with a different AWID is not accepted.
- R9: Downstream addresses may be issued several bursts ahead of their data, up to the depth of the information queues, which never overflow or underflow.
- R10: While `rst_n` is low, no valid is driven on any output channel and `up_awready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_awvalid | input | 1 | Upstream address valid |
| up_awready | output | 1 | Upstream address ready |
| up_awid | input | ID_W | Upstream write ID |
| up_awaddr | input | ADDR_W | Upstream start address |
| up_awlen | input | 8 | Upstream beats minus one |
| up_awsize | input | 3 | Log2 of bytes per beat |
| up_wvalid | input | 1 | Upstream data valid |
| up_wready | output | 1 | Upstream data ready |
| up_wdata | input | DATA_W | Upstream write data |
| up_wstrb | input | DATA_W/8 | Upstream byte strobes |
| up_bvalid | output | 1 | Upstream response valid |
| up_bready | input | 1 | Upstream response ready |
| up_bid | output | ID_W | Upstream response ID |
| up_bresp | output | 2 | Merged response code |
| dn_awvalid | output | 1 | Downstream address valid |
| dn_awready | input | 1 | Downstream address ready |
| dn_awid | output | ID_W | Downstream write ID |
| dn_awaddr | output | ADDR_W | Downstream piece address |
| dn_awlen | output | 4 | Downstream beats minus one |
| dn_awsize | output | 3 | Downstream beat size |
| dn_wvalid | output | 1 | Downstream data valid |
| dn_wready | input | 1 | Downstream data ready |
| dn_wid | output | ID_W | Write ID of the current beat |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_wstrb | output | DATA_W/8 | Downstream byte strobes |
| dn_wlast | output | 1 | Last beat of the current piece |
| dn_bvalid | input | 1 | Downstream response valid |
| dn_bready | output | 1 | Downstream response ready |
| dn_bid | input | ID_W | Downstream response ID |
| dn_bresp | input | 2 | Downstream response code |

## Verification
The assertions assume legal handshakes on both sides: a raised valid holds its payload until ready, upstream bursts are incrementing with AWSIZE no wider than the data bus, and the downstream slave answers each issued piece once, in issue order and only after its data. The stimulus keeps within these limits. Every valid it raises stays up until the handshake, sizes are drawn from 0 to 2, and the response model answers only pieces whose last beat it has already taken. The stimulus also varies IDs, lengths, ready patterns and response codes, so that throttling, multi-piece merging and run-ahead all occur.

// File: rtl/axw_pkg.sv
package axw_pkg;
  localparam int unsigned SPLIT_BEATS = 16;
  localparam int unsigned LEN_W       = $clog2(SPLIT_BEATS);
  localparam int unsigned RESP_W      = 2;

  // Severity order equals numeric order of the response encoding.
  function automatic logic [RESP_W-1:0] resp_worst(input logic [RESP_W-1:0] a,
                                                   input logic [RESP_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/axw_fifo.sv
module axw_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W:0]   wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_d = push ? wr_q + 1'b1 : wr_q;
    rd_d = pop  ? rd_q + 1'b1 : rd_q;
  end

  assign empty    = (wr_q == rd_q);
  assign full     = (wr_q[PTR_W] != rd_q[PTR_W]) &&
                    (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
  assign pop_data = mem_q[rd_q[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q[PTR_W-1:0]] <= push_data;
  end

  // R9: queue never written when full nor read when empty
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/axw_aw_split.sv
module axw_aw_split
  import axw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned OUTS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_awvalid,
  output logic              up_awready,
  input  logic [ID_W-1:0]   up_awid,
  input  logic [ADDR_W-1:0] up_awaddr,
  input  logic [7:0]        up_awlen,
  input  logic [2:0]        up_awsize,
  input  logic              txn_retired,
  output logic              dn_awvalid,
  input  logic              dn_awready,
  output logic [ID_W-1:0]   dn_awid,
  output logic [ADDR_W-1:0] dn_awaddr,
  output logic [LEN_W-1:0]  dn_awlen,
  output logic [2:0]        dn_awsize,
  input  logic              wq_full,
  input  logic              bq_full,
  output logic              info_push,
  output logic              info_last
);
  localparam int unsigned      REM_W = 9;
  localparam logic [REM_W-1:0] SPLIT = REM_W'(SPLIT_BEATS);

  logic              busy_q, busy_d;
  logic [REM_W-1:0]  rem_q, rem_d, rem_m1;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_aligned, addr_step;
  logic [ID_W-1:0]   id_q;
  logic [2:0]        size_q;
  logic [OUTS_W-1:0] outs_q, outs_d;
  logic              throttle_ok, aw_acc, dn_hs, last_burst, pos_en, outs_en;

  assign throttle_ok = (outs_q == '0) || (up_awid == id_q);
  assign up_awready  = !busy_q && throttle_ok && (outs_q != '1);
  assign aw_acc      = up_awvalid && up_awready;

  assign rem_m1      = rem_q - REM_W'(1);
  assign last_burst  = (rem_q <= SPLIT);
  assign dn_awvalid  = busy_q && !wq_full && !bq_full;
  assign dn_hs       = dn_awvalid && dn_awready;
  assign dn_awid     = id_q;
  assign dn_awaddr   = addr_q;
  assign dn_awsize   = size_q;
  assign dn_awlen    = last_burst ? rem_m1[LEN_W-1:0] : '1;
  assign info_push   = dn_hs;
  assign info_last   = last_burst;

  assign addr_aligned = (addr_q >> size_q) << size_q;
  assign addr_step    = ADDR_W'(SPLIT_BEATS) << size_q;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    if (aw_acc) begin
      busy_d = 1'b1;
      rem_d  = {1'b0, up_awlen} + REM_W'(1);
      addr_d = up_awaddr;
    end else if (dn_hs) begin
      if (last_burst) begin
        busy_d = 1'b0;
      end else begin
        rem_d  = rem_q - SPLIT;
        addr_d = addr_aligned + addr_step;
      end
    end
  end

  always_comb begin
    outs_d = outs_q;
    case ({aw_acc, txn_retired})
      2'b10:   outs_d = outs_q + 1'b1;
      2'b01:   outs_d = outs_q - 1'b1;
      default: outs_d = outs_q;
    endcase
  end

  assign pos_en  = aw_acc || dn_hs;
  assign outs_en = aw_acc ^ txn_retired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      id_q   <= '0;
      size_q <= '0;
      outs_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (pos_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (aw_acc) begin
        id_q   <= up_awid;
        size_q <= up_awsize;
      end
      if (outs_en) outs_q <= outs_d;
    end
  end

  // R3: no second acceptance right after one
  a_r3_awready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (up_awvalid && up_awready) |=> !up_awready);
  // R8: accepted address while traffic in flight matches the in-flight ID
  a_r8_throttle: assert property (@(posedge clk) disable iff (!rst_n)
    (up_awvalid && up_awready && outs_q != '0) |-> (up_awid == id_q));
  // R1: a short piece always finishes the split
  a_r1_short_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_awvalid && dn_awready && dn_awlen != '1) |=> !busy_q);
  // R2: a stalled downstream address holds its payload
  a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_awvalid && !dn_awready) |=> (dn_awvalid && $stable(dn_awaddr) && $stable(dn_awlen)));
endmodule

// File: rtl/axw_w_frame.sv
module axw_w_frame
  import axw_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                info_valid,
  input  logic [ID_W-1:0]     info_id,
  input  logic [LEN_W-1:0]    info_len,
  output logic                info_pop,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [ID_W-1:0]     dn_wid,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast
);
  logic [LEN_W-1:0] beat_q, beat_d;
  logic             w_hs;

  assign dn_wvalid = up_wvalid && info_valid;
  assign up_wready = dn_wready && info_valid;
  assign dn_wdata  = up_wdata;
  assign dn_wstrb  = up_wstrb;
  assign dn_wid    = info_id;
  assign dn_wlast  = (beat_q == info_len);
  assign w_hs      = dn_wvalid && dn_wready;
  assign info_pop  = w_hs && dn_wlast;

  always_comb begin
    beat_d = beat_q;
    if (info_pop)  beat_d = '0;
    else if (w_hs) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat_q <= '0;
    else if (w_hs) beat_q <= beat_d;
  end

  // R4: beat counter never passes the length of the piece being framed
  a_r4_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    info_valid |-> (beat_q <= info_len));
  // R4: with no piece pending the counter rests at zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !info_valid |-> (beat_q == '0));
endmodule

// File: rtl/axw_b_merge.sv
module axw_b_merge
  import axw_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              info_valid,
  input  logic              info_last,
  output logic              info_pop,
  input  logic              dn_bvalid,
  output logic              dn_bready,
  input  logic [ID_W-1:0]   dn_bid,
  input  logic [RESP_W-1:0] dn_bresp,
  output logic              up_bvalid,
  input  logic              up_bready,
  output logic [ID_W-1:0]   up_bid,
  output logic [RESP_W-1:0] up_bresp,
  output logic              txn_retired
);
  logic [RESP_W-1:0] acc_q, acc_d, merged;
  logic              b_hs;

  assign merged      = resp_worst(acc_q, dn_bresp);
  assign up_bvalid   = dn_bvalid && info_valid && info_last;
  assign up_bid      = dn_bid;
  assign up_bresp    = merged;
  assign dn_bready   = info_valid && (!info_last || up_bready);
  assign b_hs        = dn_bvalid && dn_bready;
  assign info_pop    = b_hs;
  assign txn_retired = b_hs && info_last;

  always_comb begin
    acc_d = acc_q;
    if (txn_retired) acc_d = '0;
    else if (b_hs)   acc_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (b_hs) acc_q <= acc_d;
  end

  // R7: severity seen so far never decreases inside a transaction
  a_r7_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && !info_last) |=> (acc_q >= $past(acc_q)));
  // R6: upstream response only offered when a downstream one is present
  a_r6_b_follows_dn: assert property (@(posedge clk) disable iff (!rst_n)
    up_bvalid |-> (dn_bvalid && dn_bready == up_bready));
endmodule

// File: rtl/axw_conv.sv
module axw_conv
  import axw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OUTS_W   = 4,
  parameter int unsigned WQ_DEPTH = 4,
  parameter int unsigned BQ_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_awvalid,
  output logic                up_awready,
  input  logic [ID_W-1:0]     up_awid,
  input  logic [ADDR_W-1:0]   up_awaddr,
  input  logic [7:0]          up_awlen,
  input  logic [2:0]          up_awsize,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  output logic                up_bvalid,
  input  logic                up_bready,
  output logic [ID_W-1:0]     up_bid,
  output logic [1:0]          up_bresp,
  output logic                dn_awvalid,
  input  logic                dn_awready,
  output logic [ID_W-1:0]     dn_awid,
  output logic [ADDR_W-1:0]   dn_awaddr,
  output logic [3:0]          dn_awlen,
  output logic [2:0]          dn_awsize,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [ID_W-1:0]     dn_wid,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast,
  input  logic                dn_bvalid,
  output logic                dn_bready,
  input  logic [ID_W-1:0]     dn_bid,
  input  logic [1:0]          dn_bresp
);
  localparam int unsigned WQ_W = ID_W + LEN_W;

  logic            info_push, info_last, txn_retired;
  logic            wq_full, wq_empty, wq_pop;
  logic            bq_full, bq_empty, bq_pop, bq_last;
  logic [WQ_W-1:0] wq_out;

  axw_aw_split #(.ADDR_W(ADDR_W), .ID_W(ID_W), .OUTS_W(OUTS_W)) aw_i (
    .clk(clk), .rst_n(rst_n),
    .up_awvalid(up_awvalid), .up_awready(up_awready), .up_awid(up_awid),
    .up_awaddr(up_awaddr), .up_awlen(up_awlen), .up_awsize(up_awsize),
    .txn_retired(txn_retired),
    .dn_awvalid(dn_awvalid), .dn_awready(dn_awready), .dn_awid(dn_awid),
    .dn_awaddr(dn_awaddr), .dn_awlen(dn_awlen), .dn_awsize(dn_awsize),
    .wq_full(wq_full), .bq_full(bq_full),
    .info_push(info_push), .info_last(info_last)
  );

  axw_fifo #(.WIDTH(WQ_W), .DEPTH(WQ_DEPTH)) wq_i (
    .clk(clk), .rst_n(rst_n),
    .push(info_push), .push_data({dn_awid, dn_awlen}), .full(wq_full),
    .pop(wq_pop), .pop_data(wq_out), .empty(wq_empty)
  );

  axw_fifo #(.WIDTH(1), .DEPTH(BQ_DEPTH)) bq_i (
    .clk(clk), .rst_n(rst_n),
    .push(info_push), .push_data(info_last), .full(bq_full),
    .pop(bq_pop), .pop_data(bq_last), .empty(bq_empty)
  );

  axw_w_frame #(.ID_W(ID_W), .DATA_W(DATA_W)) w_i (
    .clk(clk), .rst_n(rst_n),
    .info_valid(!wq_empty), .info_id(wq_out[WQ_W-1:LEN_W]),
    .info_len(wq_out[LEN_W-1:0]), .info_pop(wq_pop),
    .up_wvalid(up_wvalid), .up_wready(up_wready), .up_wdata(up_wdata),
    .up_wstrb(up_wstrb),
    .dn_wvalid(dn_wvalid), .dn_wready(dn_wready), .dn_wid(dn_wid),
    .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb), .dn_wlast(dn_wlast)
  );

  axw_b_merge #(.ID_W(ID_W)) b_i (
    .clk(clk), .rst_n(rst_n),
    .info_valid(!bq_empty), .info_last(bq_last), .info_pop(bq_pop),
    .dn_bvalid(dn_bvalid), .dn_bready(dn_bready), .dn_bid(dn_bid),
    .dn_bresp(dn_bresp),
    .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bid(up_bid),
    .up_bresp(up_bresp), .txn_retired(txn_retired)
  );

  // R10: nothing offered on any output channel during reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!up_bvalid && !dn_awvalid && !dn_wvalid));
endmodule

// File: tb/axw_conv_tb_top.sv
`timescale 1ns/100ps
module axw_conv_tb_top;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;
  localparam int DATA_W = 32;
  localparam int NTX    = 48;
  localparam int LIMIT  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              up_awvalid = 0, up_awready;
  logic [ID_W-1:0]   up_awid = '0;
  logic [ADDR_W-1:0] up_awaddr = '0;
  logic [7:0]        up_awlen = '0;
  logic [2:0]        up_awsize = '0;
  logic              up_wvalid = 0, up_wready;
  logic [DATA_W-1:0] up_wdata = '0;
  logic [3:0]        up_wstrb = '0;
  logic              up_bvalid, up_bready = 0;
  logic [ID_W-1:0]   up_bid;
  logic [1:0]        up_bresp;
  logic              dn_awvalid, dn_awready = 0;
  logic [ID_W-1:0]   dn_awid;
  logic [ADDR_W-1:0] dn_awaddr;
  logic [3:0]        dn_awlen;
  logic [2:0]        dn_awsize;
  logic              dn_wvalid, dn_wready = 0, dn_wlast;
  logic [ID_W-1:0]   dn_wid;
  logic [DATA_W-1:0] dn_wdata;
  logic [3:0]        dn_wstrb;
  logic              dn_bvalid = 0, dn_bready;
  logic [ID_W-1:0]   dn_bid = '0;
  logic [1:0]        dn_bresp = '0;

  axw_conv dut_i (.*);

  typedef struct { logic [ADDR_W-1:0] addr; int len; int id; int size; int txn; bit last; } aw_exp_t;
  typedef struct { logic [DATA_W-1:0] data; int strb; int id; bit last; } w_exp_t;

  aw_exp_t aw_q[$];
  w_exp_t  w_q[$];
  aw_exp_t pend_q[$];
  logic [DATA_W-1:0] ub_data[$];
  int                ub_strb[$];

  int tx_id[NTX], tx_len[NTX], tx_size[NTX], tx_bexp[NTX];
  logic [ADDR_W-1:0] tx_addr[NTX];

  int checks = 0, fails = 0;
  int acc_cnt = 0, bdone_cnt = 0, dn_aw_cnt = 0, wburst_done = 0, bsent = 0, bidx = 0;
  int max_lead = 0, last_id = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected pieces and beats for one upstream transaction (R1, R2, R4)
  task automatic build(input int t, input int base);
    logic [ADDR_W-1:0] a;
    int rem;
    int wi;
    a = tx_addr[t];
    rem = tx_len[t] + 1;
    wi = 0;
    while (rem > 0) begin
      int n;
      n = (rem > 16) ? 16 : rem;
      aw_q.push_back('{a, n - 1, tx_id[t], tx_size[t], t, rem <= 16});
      for (int k = 0; k < n; k++) begin
        w_q.push_back('{ub_data[base + wi], ub_strb[base + wi], tx_id[t], k == n - 1});
        wi++;
      end
      a = (a >> tx_size[t]) << tx_size[t];
      a = a + (ADDR_W'(16) << tx_size[t]);
      rem -= n;
    end
  endtask

  function automatic int pick_resp();
    int r;
    r = int'($urandom % 20);
    if (r < 12) return 0;
    if (r < 15) return 1;
    if (r < 18) return 2;
    return 3;
  endfunction

  // Upstream address driver: R3, R8
  task automatic aw_drv();
    int t = 0; int gap = 0; bit hs = 0; bit gap_chk = 0;
    forever begin
      @(negedge clk);
      if (hs) begin acc_cnt++; last_id = tx_id[t]; t++; hs = 0; gap_chk = 1; up_awvalid = 0; end
      if (!up_awvalid && t < NTX) begin
        if (gap > 0) gap--;
        else begin
          up_awvalid = 1; up_awid = ID_W'(tx_id[t]); up_awaddr = tx_addr[t];
          up_awlen = 8'(tx_len[t]); up_awsize = 3'(tx_size[t]);
        end
      end
      #1;
      if (gap_chk) begin
        chk(up_awready == 1'b0, "R3", "up_awready after accept", up_awready, 0);
        gap_chk = 0;
      end
      if (up_awvalid && tx_id[t] != last_id && acc_cnt != bdone_cnt)
        chk(up_awready == 1'b0, "R8", "up_awready with foreign ID", up_awready, 0);
      if (up_awvalid && up_awready) begin hs = 1; gap = int'($urandom % 3); end
    end
  endtask

  // Upstream data driver: R5
  task automatic w_drv();
    int b = 0; bit hs = 0;
    forever begin
      @(negedge clk);
      if (hs) begin b++; hs = 0; up_wvalid = 0; end
      if (!up_wvalid && b < ub_data.size() && ($urandom % 5) != 0) begin
        up_wvalid = 1; up_wdata = ub_data[b]; up_wstrb = 4'(ub_strb[b]);
      end
      #1;
      if (up_wvalid && dn_wready && dn_aw_cnt > wburst_done) begin
        chk(up_wready == 1'b1, "R5", "up_wready", up_wready, 1);
        chk(dn_wvalid == 1'b1, "R5", "dn_wvalid", dn_wvalid, 1);
      end
      if (up_wvalid && up_wready) hs = 1;
    end
  endtask

  // Downstream address slave: R1, R2
  task automatic dn_aw_slave();
    bit hs = 0;
    forever begin
      @(negedge clk);
      if (hs) begin
        dn_aw_cnt++; hs = 0;
        if (dn_aw_cnt - wburst_done > max_lead) max_lead = dn_aw_cnt - wburst_done;
      end
      dn_awready = ($urandom % 4) != 0;
      #1;
      if (dn_awvalid && dn_awready) begin
        hs = 1;
        if (aw_q.size() == 0) chk(0, "R1", "unexpected piece", dn_awaddr, 0);
        else begin
          aw_exp_t e;
          e = aw_q.pop_front();
          chk(dn_awlen == 4'(e.len), "R1", "dn_awlen", dn_awlen, e.len);
          chk(dn_awaddr == e.addr, "R2", "dn_awaddr", dn_awaddr, e.addr);
          chk(dn_awid == ID_W'(e.id), "R2", "dn_awid", dn_awid, e.id);
          chk(dn_awsize == 3'(e.size), "R2", "dn_awsize", dn_awsize, e.size);
          pend_q.push_back(e);
        end
      end
    end
  endtask

  // Downstream data slave: R4
  task automatic dn_w_slave();
    bit hs = 0; bit was_last = 0;
    forever begin
      @(negedge clk);
      if (hs) begin if (was_last) wburst_done++; hs = 0; end
      dn_wready = ($urandom % 5) != 0;
      #1;
      if (dn_wvalid && dn_wready) begin
        hs = 1; was_last = dn_wlast;
        if (w_q.size() == 0) chk(0, "R4", "unexpected beat", dn_wdata, 0);
        else begin
          w_exp_t e;
          e = w_q.pop_front();
          chk(dn_wdata == e.data, "R4", "dn_wdata", dn_wdata, e.data);
          chk(dn_wstrb == 4'(e.strb), "R4", "dn_wstrb", dn_wstrb, e.strb);
          chk(dn_wid == ID_W'(e.id), "R4", "dn_wid", dn_wid, e.id);
          chk(dn_wlast == e.last, "R4", "dn_wlast", dn_wlast, e.last);
        end
      end
    end
  endtask

  // Downstream response model: R6 (no early upstream response)
  task automatic b_slave();
    bit hs = 0;
    forever begin
      @(negedge clk);
      if (hs) begin bsent++; void'(pend_q.pop_front()); hs = 0; dn_bvalid = 0; end
      if (!dn_bvalid && bsent < wburst_done && pend_q.size() > 0 && ($urandom % 3) == 0) begin
        int r;
        r = pick_resp();
        dn_bvalid = 1; dn_bid = ID_W'(pend_q[0].id); dn_bresp = 2'(r);
        if (r > tx_bexp[pend_q[0].txn]) tx_bexp[pend_q[0].txn] = r;
      end
      #1;
      if (dn_bvalid && !pend_q[0].last)
        chk(up_bvalid == 1'b0, "R6", "up_bvalid on inner piece", up_bvalid, 0);
      if (dn_bvalid && dn_bready) hs = 1;
    end
  endtask

  // Upstream response monitor: R6, R7
  task automatic up_b_mon();
    bit hs = 0;
    forever begin
      @(negedge clk);
      if (hs) begin bidx++; bdone_cnt++; hs = 0; end
      up_bready = ($urandom % 10) < 7;
      #1;
      if (up_bvalid && up_bready) begin
        hs = 1;
        if (bidx >= NTX) chk(0, "R6", "extra upstream response", bidx, NTX);
        else begin
          chk(up_bid == ID_W'(tx_id[bidx]), "R6", "up_bid", up_bid, tx_id[bidx]);
          chk(up_bresp == 2'(tx_bexp[bidx]), "R7", "up_bresp", up_bresp, tx_bexp[bidx]);
        end
      end
    end
  endtask

  initial begin
    int cyc;
    int base;
    int cur_id;
    int lens[6];
    void'($urandom(32'd20240611));
    lens = '{0, 15, 16, 17, 255, 40};
    base = 0;
    cur_id = 0;
    for (int t = 0; t < NTX; t++) begin
      int sel;
      sel = int'($urandom % 4);
      if (t < 6) tx_len[t] = lens[t];
      else if (sel == 0) tx_len[t] = int'($urandom % 16);
      else if (sel == 1) tx_len[t] = 16 + int'($urandom % 16);
      else tx_len[t] = int'($urandom % 256);
      tx_size[t] = (t < 6) ? 2 : int'($urandom % 3);
      tx_addr[t] = (t == 5) ? 32'h0000_1006 : $urandom;
      if (t >= 6 && ($urandom % 4) == 0) cur_id = int'($urandom % 4);
      tx_id[t] = cur_id;
      tx_bexp[t] = 0;
      for (int k = 0; k <= tx_len[t]; k++) begin
        ub_data.push_back($urandom);
        ub_strb.push_back(int'($urandom % 16));
      end
      build(t, base);
      base += tx_len[t] + 1;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R10: reset state
    chk(up_bvalid == 1'b0, "R10", "up_bvalid in reset", up_bvalid, 0);
    chk(dn_awvalid == 1'b0, "R10", "dn_awvalid in reset", dn_awvalid, 0);
    chk(dn_wvalid == 1'b0, "R10", "dn_wvalid in reset", dn_wvalid, 0);
    chk(up_awready == 1'b1, "R10", "up_awready in reset", up_awready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    fork
      aw_drv();
      w_drv();
      dn_aw_slave();
      dn_w_slave();
      b_slave();
      up_b_mon();
    join_none

    cyc = 0;
    while (bidx < NTX && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog R6: responses %0d expected %0d", bidx, NTX);
    end
    repeat (5) @(posedge clk);
    chk(aw_q.size() == 0, "R1", "pieces left unissued", aw_q.size(), 0);
    chk(w_q.size() == 0, "R4", "beats left unsent", w_q.size(), 0);
    chk(bidx == NTX, "R6", "upstream responses", bidx, NTX);
    chk(max_lead >= 2, "R9", "address run-ahead", max_lead, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule